// File: doc/BRIEF.md
# Six-pin GPIO port with serial-transmit alternate function

This block is a six-pin general-purpose I/O port controlled through a small register bus. Software sets each pin's direction, writes the value driven on output pins, and reads back a mix of live pin levels and latched output values. It drives per-pin data and enable signals toward external pad models, and it samples the pad inputs through a two-stage synchronizer.

Two pins, 0 and 3, can instead carry the transmit lines of two serial channels. A function-select bit hands the pin to the serial transmitter. An open-drain enable bit on those same two pins lets the pin pull low and float high, by withdrawing its output enable whenever the selected data is 1. The other four pins keep their function-select bits as plain storage, which has no effect on what they drive.

Register map (2-bit address, 8-bit data, pins in bits 5..0): address 0 is the data register, address 1 the direction register (1 = output), address 2 the function-select register (1 = alternate), and address 3 the open-drain enable register (1 = open-drain).

Top module: `gpio_altport`

## Requirements
- R1: After reset the direction, function-select and open-drain registers are 0, the output latch is 6'b111111, pad_oe is 0 on all pins, and pad_out is all ones.
- R2: pad_oe[i] equals direction bit i for every push-pull pin, and the direction register reads back the value last written to it.
- R3: An output pin that has no alternate function selected drives the output latch bit on pad_out.
- R4: When function bit 0 is 1, pin 0 drives ser_tx[0]. When function bit 3 is 1, pin 3 drives ser_tx[1].
- R5: Function bits 1, 2, 4 and 5 have no effect on pad_out, and all six function bits read back as written.
- R6: When the open-drain bit of pin 0 or 3 is 1, that pin's pad_out is 0 and its pad_oe is its direction bit AND NOT its selected data.
- R7: Open-drain bits exist only at positions 0 and 3. Other positions read as 0 and have no effect on the pads.
- R8: A read of address 0 returns the latch bit for output pins and the synchronized pad_in bit for input pins. A pad_in change becomes visible in the third read cycle after it, counting from the first clock edge.
- R9: Bits 7 and 6 of every read return 0.
- R10: A write strobe is sampled at a clock edge. The pad outputs change at the following edge, and ser_tx reaches pad_out one edge after it changes. Read data is registered one edge after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 6 | Pin input levels |
| ser_tx | input | 2 | Serial transmit lines (0 to pin 0, 1 to pin 3) |
| pad_out | output | 6 | Pin output data |
| pad_oe | output | 6 | Pin output enable |

## Verification
The hardest case to reach is the interaction of open-drain with the alternate function. It only shows up when an output pin in open-drain mode is fed by a toggling serial line, so that pad_oe, not pad_out, must follow the transmit level. The bench reaches it by sweeping direction, function, latch and open-drain settings together with all four ser_tx combinations. It computes the expected enable and data for each pin arithmetically. The synchronizer latency is pinned by reading the data register three times in a row after a single pad_in change.

// File: rtl/gpio_altport_pkg.sv
package gpio_altport_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_FUNC = 2'd2,
    SEL_ODEN = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_altport_pkg::*;
#(
  parameter int              NPINS    = 6,
  parameter int              DW       = 8,
  parameter logic [NPINS-1:0] OD_MASK = 6'b001001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  input  logic [NPINS-1:0]  pins_sync,
  output logic [NPINS-1:0]  latch_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  func_q,
  output logic [NPINS-1:0]  od_q,
  output logic [DW-1:0]     rdata
);
  localparam int PAD_W = DW - NPINS;

  logic [NPINS-1:0] wbits;
  logic [NPINS-1:0] rd_bits;
  reg_sel_e         sel;

  assign wbits = wdata[NPINS-1:0];
  assign sel   = reg_sel_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
      dir_q   <= '0;
      func_q  <= '0;
      od_q    <= '0;
    end else if (we) begin
      unique case (sel)
        SEL_DATA: latch_q <= wbits;
        SEL_DIR:  dir_q   <= wbits;
        SEL_FUNC: func_q  <= wbits;
        SEL_ODEN: od_q    <= wbits & OD_MASK;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: rd_bits = (dir_q & latch_q) | (~dir_q & pins_sync);
      SEL_DIR:  rd_bits = dir_q;
      SEL_FUNC: rd_bits = func_q;
      SEL_ODEN: rd_bits = od_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= {{PAD_W{1'b0}}, rd_bits};
  end
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv #(
  parameter bit HAS_ALT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic latch_bit,
  input  logic dir_bit,
  input  logic func_bit,
  input  logic od_bit,
  input  logic alt_bit,
  output logic pad_out,
  output logic pad_oe
);
  logic sel_data;
  logic use_od;
  logic out_d;
  logic oe_d;

  assign sel_data = (HAS_ALT && func_bit) ? alt_bit : latch_bit;
  assign use_od   = HAS_ALT && od_bit;
  assign out_d    = use_od ? 1'b0 : sel_data;
  assign oe_d     = use_od ? (dir_bit & ~sel_data) : dir_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b1;
      pad_oe  <= 1'b0;
    end else begin
      pad_out <= out_d;
      pad_oe  <= oe_d;
    end
  end
endmodule

// File: rtl/gpio_altport.sv
module gpio_altport
  import gpio_altport_pkg::*;
#(
  parameter int NPINS     = 6,
  parameter int DW        = 8,
  parameter int ALT_PIN_A = 0,
  parameter int ALT_PIN_B = 3,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  input  logic [1:0]        ser_tx,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  localparam logic [NPINS-1:0] ALT_MASK =
    NPINS'((1 << ALT_PIN_A) | (1 << ALT_PIN_B));

  logic [NPINS-1:0] pins_sync;
  logic [NPINS-1:0] latch_q;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] func_q;
  logic [NPINS-1:0] od_q;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_LEN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (pins_sync)
  );

  gpio_regs #(.NPINS(NPINS), .DW(DW), .OD_MASK(ALT_MASK)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .we        (bus_we),
    .wdata     (bus_wdata),
    .pins_sync (pins_sync),
    .latch_q   (latch_q),
    .dir_q     (dir_q),
    .func_q    (func_q),
    .od_q      (od_q),
    .rdata     (bus_rdata)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    if (i == ALT_PIN_A || i == ALT_PIN_B) begin : g_alt
      localparam int TXI = (i == ALT_PIN_A) ? 0 : 1;
      gpio_pin_drv #(.HAS_ALT(1'b1)) u_drv (
        .clk       (clk),
        .rst       (rst),
        .latch_bit (latch_q[i]),
        .dir_bit   (dir_q[i]),
        .func_bit  (func_q[i]),
        .od_bit    (od_q[i]),
        .alt_bit   (ser_tx[TXI]),
        .pad_out   (pad_out[i]),
        .pad_oe    (pad_oe[i])
      );
    end else begin : g_plain
      gpio_pin_drv #(.HAS_ALT(1'b0)) u_drv (
        .clk       (clk),
        .rst       (rst),
        .latch_bit (latch_q[i]),
        .dir_bit   (dir_q[i]),
        .func_bit  (func_q[i]),
        .od_bit    (1'b0),
        .alt_bit   (1'b0),
        .pad_out   (pad_out[i]),
        .pad_oe    (pad_oe[i])
      );
    end
  end
endmodule

// File: rtl/gpio_altport_chk.sv
module gpio_altport_chk #(
  parameter int NPINS     = 6,
  parameter int DW        = 8,
  parameter int ALT_PIN_A = 0,
  parameter int ALT_PIN_B = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [DW-1:0]    bus_rdata,
  input logic [1:0]       ser_tx,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] latch_q,
  input logic [NPINS-1:0] dir_q,
  input logic [NPINS-1:0] func_q,
  input logic [NPINS-1:0] od_q
);
  localparam logic [NPINS-1:0] PLAIN_MASK =
    ~NPINS'((1 << ALT_PIN_A) | (1 << ALT_PIN_B));

  AST_RESET_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_out == '1)); // R1

  AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & ~$past(dir_q)) == '0)); // R2

  AST_PLAIN_FOLLOWS_LATCH: assert property (@(posedge clk) disable iff (rst)
    (((pad_out ^ $past(latch_q)) & PLAIN_MASK) == '0)); // R5

  AST_ALT_A_TX: assert property (@(posedge clk) disable iff (rst)
    $past(func_q[ALT_PIN_A] && !od_q[ALT_PIN_A]) |-> pad_out[ALT_PIN_A] == $past(ser_tx[0])); // R4

  AST_ALT_B_TX: assert property (@(posedge clk) disable iff (rst)
    $past(func_q[ALT_PIN_B] && !od_q[ALT_PIN_B]) |-> pad_out[ALT_PIN_B] == $past(ser_tx[1])); // R4

  AST_OD_A_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    $past(od_q[ALT_PIN_A]) |-> !pad_out[ALT_PIN_A]); // R6

  AST_OD_B_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    $past(od_q[ALT_PIN_B]) |-> !pad_out[ALT_PIN_B]); // R6

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DW-1:NPINS] == '0); // R9
endmodule

bind gpio_altport gpio_altport_chk #(
  .NPINS(NPINS), .DW(DW), .ALT_PIN_A(ALT_PIN_A), .ALT_PIN_B(ALT_PIN_B)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rdata (bus_rdata),
  .ser_tx    (ser_tx),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .latch_q   (latch_q),
  .dir_q     (dir_q),
  .func_q    (func_q),
  .od_q      (od_q)
);

// File: tb/gpio_altport_test.sv
module gpio_altport_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [5:0] pad_in = '0;
  logic [1:0] ser_tx = '0;
  logic [5:0] pad_out;
  logic [5:0] pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_altport uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .ser_tx(ser_tx), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  function automatic logic [5:0] exp_sel(input logic [5:0] lat, input logic [5:0] fn,
                                         input logic [1:0] tx);
    logic [5:0] s;
    s = lat;
    if (fn[0]) s[0] = tx[0];
    if (fn[3]) s[3] = tx[1];
    return s;
  endfunction

  function automatic logic [5:0] exp_out(input logic [5:0] lat, input logic [5:0] fn,
                                         input logic [5:0] od, input logic [1:0] tx);
    logic [5:0] s;
    s = exp_sel(lat, fn, tx);
    if (od[0]) s[0] = 1'b0;
    if (od[3]) s[3] = 1'b0;
    return s;
  endfunction

  function automatic logic [5:0] exp_oe(input logic [5:0] dr, input logic [5:0] lat,
                                        input logic [5:0] fn, input logic [5:0] od,
                                        input logic [1:0] tx);
    logic [5:0] s, e;
    s = exp_sel(lat, fn, tx);
    e = dr;
    if (od[0]) e[0] = dr[0] & ~s[0];
    if (od[3]) e[3] = dr[3] & ~s[3];
    return e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [5:0] lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();

    // R1 reset state
    chk("R1 oe", {2'b0, pad_oe}, 8'h00);
    chk("R1 out", {2'b0, pad_out}, 8'h3F);
    rd(2'd1, r); chk("R1 dir", r, 8'h00);
    rd(2'd2, r); chk("R1 func", r, 8'h00);
    rd(2'd3, r); chk("R1 oden", r, 8'h00);
    wr(2'd1, 8'h3F);
    settle();
    chk("R1 latch ones", {2'b0, pad_out}, 8'h3F);
    rd(2'd0, r); chk("R1 latch read", r, 8'h3F);

    // R2 direction sweep
    for (int d = 0; d < 64; d++) begin
      wr(2'd1, 8'(d));
      settle();
      chk("R2 oe", {2'b0, pad_oe}, 8'(d));
      rd(2'd1, r); chk("R2 readback", r, 8'(d));
    end

    // R3 / R8 latch sweep, all outputs
    wr(2'd1, 8'h3F);
    for (int v = 0; v < 64; v++) begin
      wr(2'd0, 8'(v));
      settle();
      chk("R3 out", {2'b0, pad_out}, 8'(v));
      rd(2'd0, r); chk("R8 latch read", r, 8'(v));
    end

    // R4 / R5 function sweep
    for (int li = 0; li < 2; li++) begin
      lat = (li == 0) ? 6'b101010 : 6'b010101;
      wr(2'd0, {2'b0, lat});
      for (int f = 0; f < 64; f++) begin
        wr(2'd2, 8'(f));
        for (int t = 0; t < 4; t++) begin
          ser_tx = 2'(t);
          settle();
          chk("R4 R5 out", {2'b0, pad_out}, {2'b0, exp_out(lat, 6'(f), 6'h00, 2'(t))});
          chk("R4 oe", {2'b0, pad_oe}, 8'h3F);
        end
        rd(2'd2, r); chk("R5 func readback", r, 8'(f));
      end
    end

    // R7 open-drain positions
    wr(2'd3, 8'hFF);
    rd(2'd3, r); chk("R7 oden readback", r, 8'h09);

    // R6 / R7 open-drain combinations
    for (int di = 0; di < 3; di++) begin
      logic [5:0] dr;
      dr = (di == 0) ? 6'h00 : (di == 1) ? 6'h3F : 6'h09;
      wr(2'd1, {2'b0, dr});
      for (int fi = 0; fi < 2; fi++) begin
        logic [5:0] fn;
        fn = (fi == 0) ? 6'h00 : 6'h09;
        wr(2'd2, {2'b0, fn});
        for (int lv = 0; lv < 2; lv++) begin
          lat = (lv == 0) ? 6'h00 : 6'h3F;
          wr(2'd0, {2'b0, lat});
          for (int t = 0; t < 4; t++) begin
            ser_tx = 2'(t);
            settle();
            chk("R6 R7 out", {2'b0, pad_out}, {2'b0, exp_out(lat, fn, 6'h09, 2'(t))});
            chk("R6 R7 oe", {2'b0, pad_oe}, {2'b0, exp_oe(dr, lat, fn, 6'h09, 2'(t))});
          end
        end
      end
    end
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h00);

    // R8 mixed read sweep
    lat = 6'b110011;
    wr(2'd0, {2'b0, lat});
    for (int d = 0; d < 64; d++) begin
      wr(2'd1, 8'(d));
      for (int p = 0; p < 2; p++) begin
        pad_in = (p == 0) ? 6'h15 : 6'h2A;
        settle(); settle();
        rd(2'd0, r);
        chk("R8 mixed", r, {2'b0, (6'(d) & lat) | (~6'(d) & pad_in)});
      end
    end

    // R8 synchronizer latency
    wr(2'd1, 8'h00);
    pad_in = 6'h00;
    repeat (3) settle();
    pad_in = 6'h3F;
    rd(2'd0, r); chk("R8 latency 1", r, 8'h00);
    rd(2'd0, r); chk("R8 latency 2", r, 8'h00);
    rd(2'd0, r); chk("R8 latency 3", r, 8'h3F);

    // R9 upper bits
    wr(2'd1, 8'hFF); rd(2'd1, r); chk("R9 dir upper", r, 8'h3F);
    wr(2'd2, 8'hC0); rd(2'd2, r); chk("R9 func upper", r, 8'h00);
    wr(2'd0, 8'hFF); rd(2'd0, r); chk("R9 data upper", r, 8'h3F);

    // R10 timing: pads one edge after the register
    wr(2'd0, 8'h00);
    settle();
    wr(2'd0, 8'h2D);
    chk("R10 not yet", {2'b0, pad_out}, 8'h00);
    settle();
    chk("R10 updated", {2'b0, pad_out}, 8'h2D);
    wr(2'd2, 8'h01);
    settle();
    ser_tx = 2'b00;
    settle();
    ser_tx = 2'b01;
    chk("R10 tx before edge", {2'b0, pad_out}, 8'h2C);
    settle();
    chk("R10 tx after edge", {2'b0, pad_out}, 8'h2D);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule